// File: doc/BRIEF.md
# Bus-Slave Teletype Serial Controller

This block is a memory-mapped slave on an asynchronous parallel processor bus. It turns bytes written by the CPU into asynchronous serial characters for a teletype, and it turns characters arriving from the teletype back into bytes the CPU can read. Software reaches three registers: status, control and data. It starts each access by pulling an active-low strobe low. The level of an active-low direction line picks a write or a read. The block answers each access to one of its registers with a single-clock active-low completion pulse, which releases the bus.

Each serial character is an 11-bit frame: a start bit of 0, eight data bits sent least significant bit first, and two stop bits of 1. Every bit lasts `CLKS_PER_BIT` clocks. A transfer-pending flag in the status register is the OR of "transmitter ready" and "byte received". When the enable bit in the control register is set, this flag drives a level-2 interrupt request. When the bit is clear, software polls the status register instead.

Top module: `tty_bus_ctrl`

## Requirements
- R1: Accesses to addresses 0xF800 (status), 0xF806 (control) and 0xF808 (data) are answered by `bus_done_no` going low for exactly one clock. The pulse comes in the cycle after the falling edge of `bus_req_ni` is recognised. For reads, `bus_rdata_o` is valid in that same cycle.
- R2: An access to any other address produces no completion pulse and changes no register.
- R3: The status register reads bit0 = transmitter ready, bit1 = byte received, bit2 = framing error, bit7 = transfer pending (bit0 OR bit1), and 0 in all other bits. Writes to it have no effect.
- R4: Control bit0 is the interrupt enable. A write to control sets it, and a read returns it with all other bits 0.
- R5: `irq_l2_o` is high exactly when the interrupt enable is set and the transfer-pending flag is set.
- R6: A data write while the transmitter is ready sends the frame 0, d0..d7, 1, 1 on `ser_tx_o`, each bit lasting CLKS_PER_BIT clocks. Transmitter ready stays 0 until the frame ends. The line idles at 1.
- R7: A data write while a frame is being sent is ignored: it causes no second frame.
- R8: A received frame with valid stop bits loads its byte and sets byte received. A data read returns that byte and clears byte received and framing error.
- R9: A received frame whose first stop bit is 0 sets the framing-error status bit.
- R10: A low pulse on `ser_rx_i` shorter than half a bit period is rejected as a start bit.
- R11: After reset, status reads 0x81 and control reads 0x00, `ser_tx_o` is 1, `bus_done_no` is 1 and `irq_l2_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_req_ni | input | 1 | Bus access strobe, active low |
| bus_addr_i | input | 16 | Bus address |
| bus_wr_ni | input | 1 | Direction level: low = write, high = read |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, valid while completion is low |
| bus_done_no | output | 1 | Completion strobe, active low, one clock |
| irq_l2_o | output | 1 | Level-2 interrupt request |
| ser_tx_o | output | 1 | Serial line to teletype |
| ser_rx_i | input | 1 | Serial line from teletype |

## Verification
The bench sends and receives all 256 byte values. A design that reversed the bit order, dropped a stop bit or mistimed the bit period would corrupt the captured frames or the bytes read back. It probes addresses that lie next to the three registers. A loose decoder would then acknowledge them or change a register, and a wrong completion would show as a pulse longer or shorter than one clock. It writes data while a frame is being sent: an unguarded transmitter would restart or send a second frame. It also sends a bad stop bit, which must set the framing-error bit, and a short start glitch, which must not be taken as a received byte. Finally it toggles the interrupt enable, so an ungated or stuck interrupt disagrees with the pending flag.

// File: rtl/tty_pkg.sv
package tty_pkg;
  localparam int FRAME_BITS = 11;
  localparam int RX_BITS    = 10;  // 8 data + 2 stop
  localparam logic [3:0] OFS_STAT = 4'h0;
  localparam logic [3:0] OFS_CTRL = 4'h6;
  localparam logic [3:0] OFS_DATA = 4'h8;
  localparam int ST_TXRDY = 0;
  localparam int ST_RXRDY = 1;
  localparam int ST_FERR  = 2;
  localparam int ST_PDT   = 7;
  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_SHIFT} rx_state_e;
endpackage

// File: rtl/tty_tx_ser.sv
module tty_tx_ser #(
  parameter int CLKS_PER_BIT = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [7:0] data_i,
  output logic       busy_o,
  output logic       tx_o
);
  import tty_pkg::*;
  localparam int CW = $clog2(CLKS_PER_BIT);
  localparam int IW = $clog2(FRAME_BITS);

  logic [FRAME_BITS-1:0] sh_q;
  logic [CW-1:0]         cnt_q;
  logic [IW-1:0]         idx_q;
  logic                  busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '1;
      cnt_q  <= '0;
      idx_q  <= '0;
      busy_q <= 1'b0;
    end else if (!busy_q) begin
      if (start_i) begin
        sh_q   <= {2'b11, data_i, 1'b0};
        cnt_q  <= '0;
        idx_q  <= '0;
        busy_q <= 1'b1;
      end
    end else if (cnt_q == CW'(CLKS_PER_BIT - 1)) begin
      cnt_q <= '0;
      sh_q  <= {1'b1, sh_q[FRAME_BITS-1:1]};
      if (idx_q == IW'(FRAME_BITS - 1)) busy_q <= 1'b0;
      else                              idx_q  <= idx_q + 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign busy_o = busy_q;
  assign tx_o   = busy_q ? sh_q[0] : 1'b1;
endmodule

// File: rtl/tty_rx_deser.sv
module tty_rx_deser #(
  parameter int CLKS_PER_BIT = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rx_i,
  output logic       valid_o,
  output logic [7:0] byte_o,
  output logic       ferr_o
);
  import tty_pkg::*;
  localparam int CW   = $clog2(CLKS_PER_BIT);
  localparam int IW   = $clog2(RX_BITS);
  localparam int HALF = CLKS_PER_BIT / 2;

  logic [1:0]         sync_q;
  logic               rx_s;
  rx_state_e          st_q;
  logic [CW-1:0]      cnt_q;
  logic [IW-1:0]      idx_q;
  logic [RX_BITS-1:0] sh_q;
  logic [RX_BITS-1:0] sh_nxt;

  assign rx_s   = sync_q[1];
  assign sh_nxt = {rx_s, sh_q[RX_BITS-1:1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q  <= 2'b11;
      st_q    <= RX_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      sh_q    <= '0;
      valid_o <= 1'b0;
      byte_o  <= '0;
      ferr_o  <= 1'b0;
    end else begin
      sync_q  <= {sync_q[0], rx_i};
      valid_o <= 1'b0;
      unique case (st_q)
        RX_IDLE: if (!rx_s) begin
          cnt_q <= '0;
          st_q  <= RX_START;
        end
        RX_START: begin
          if (rx_s) st_q <= RX_IDLE;  // glitch
          else if (cnt_q == CW'(HALF - 1)) begin
            cnt_q <= '0;
            idx_q <= '0;
            st_q  <= RX_SHIFT;
          end else cnt_q <= cnt_q + 1'b1;
        end
        RX_SHIFT: begin
          if (cnt_q == CW'(CLKS_PER_BIT - 1)) begin
            cnt_q <= '0;
            sh_q  <= sh_nxt;
            if (idx_q == IW'(RX_BITS - 1)) begin
              st_q    <= RX_IDLE;
              valid_o <= 1'b1;
              byte_o  <= sh_nxt[7:0];
              ferr_o  <= ~(sh_nxt[8] & sh_nxt[9]);
            end else idx_q <= idx_q + 1'b1;
          end else cnt_q <= cnt_q + 1'b1;
        end
        default: st_q <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tty_bus_ctrl.sv
module tty_bus_ctrl #(
  parameter int          CLKS_PER_BIT = 16,
  parameter logic [11:0] BASE_HI      = 12'hF80
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        bus_req_ni,
  input  logic [15:0] bus_addr_i,
  input  logic        bus_wr_ni,
  input  logic [7:0]  bus_wdata_i,
  output logic [7:0]  bus_rdata_o,
  output logic        bus_done_no,
  output logic        irq_l2_o,
  output logic        ser_tx_o,
  input  logic        ser_rx_i
);
  import tty_pkg::*;

  logic       req_q, stb, wr;
  logic       sel_stat, sel_ctrl, sel_data, hit;
  logic       irq_en_q, rx_rdy_q, ferr_q, done_q;
  logic [7:0] rx_byte_q, rdata_q, stat_w;
  logic       tx_busy, tx_start;
  logic       rx_valid, rx_ferr;
  logic [7:0] rx_byte;

  assign stb      = req_q & ~bus_req_ni;
  assign wr       = ~bus_wr_ni;
  assign sel_stat = (bus_addr_i == {BASE_HI, OFS_STAT});
  assign sel_ctrl = (bus_addr_i == {BASE_HI, OFS_CTRL});
  assign sel_data = (bus_addr_i == {BASE_HI, OFS_DATA});
  assign hit      = sel_stat | sel_ctrl | sel_data;
  assign tx_start = stb & sel_data & wr;

  always_comb begin
    stat_w           = '0;
    stat_w[ST_TXRDY] = ~tx_busy;
    stat_w[ST_RXRDY] = rx_rdy_q;
    stat_w[ST_FERR]  = ferr_q;
    stat_w[ST_PDT]   = ~tx_busy | rx_rdy_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q     <= 1'b1;
      done_q    <= 1'b1;
      irq_en_q  <= 1'b0;
      rx_rdy_q  <= 1'b0;
      ferr_q    <= 1'b0;
      rx_byte_q <= '0;
      rdata_q   <= '0;
    end else begin
      req_q  <= bus_req_ni;
      done_q <= ~(stb & hit);
      if (stb && hit) begin
        if (wr) begin
          if (sel_ctrl) irq_en_q <= bus_wdata_i[0];
        end else begin
          unique case (1'b1)
            sel_stat: rdata_q <= stat_w;
            sel_ctrl: rdata_q <= {7'd0, irq_en_q};
            default: begin
              rdata_q  <= rx_byte_q;
              rx_rdy_q <= 1'b0;
              ferr_q   <= 1'b0;
            end
          endcase
        end
      end
      // new character wins over a concurrent read clear
      if (rx_valid) begin
        rx_rdy_q  <= 1'b1;
        ferr_q    <= rx_ferr;
        rx_byte_q <= rx_byte;
      end
    end
  end

  tty_tx_ser #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_tx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(tx_start),
    .data_i (bus_wdata_i),
    .busy_o (tx_busy),
    .tx_o   (ser_tx_o)
  );

  tty_rx_deser #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_rx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rx_i   (ser_rx_i),
    .valid_o(rx_valid),
    .byte_o (rx_byte),
    .ferr_o (rx_ferr)
  );

  assign bus_rdata_o = rdata_q;
  assign bus_done_no = done_q;
  assign irq_l2_o    = irq_en_q & stat_w[ST_PDT];
endmodule

// File: rtl/tty_bus_ctrl_chk.sv
module tty_bus_ctrl_chk #(
  parameter logic [11:0] BASE_HI = 12'hF80
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        bus_req_ni,
  input logic [15:0] bus_addr_i,
  input logic        bus_done_no,
  input logic        irq_l2_o,
  input logic        ser_tx_o,
  input logic        irq_en_q,
  input logic        tx_busy
);
  // R1
  done_one_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_done_no |=> bus_done_no);
  // R1
  done_after_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_done_no |-> $past(!bus_req_ni));
  // R2
  done_mapped_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_done_no |-> ($past(bus_addr_i) == {BASE_HI, 4'h0} ||
                      $past(bus_addr_i) == {BASE_HI, 4'h6} ||
                      $past(bus_addr_i) == {BASE_HI, 4'h8}));
  // R5
  irq_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_l2_o |-> irq_en_q);
  // R6
  tx_idle_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_busy |-> ser_tx_o);
  // R6
  tx_start_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_busy) |-> !ser_tx_o);
endmodule

bind tty_bus_ctrl tty_bus_ctrl_chk #(.BASE_HI(BASE_HI)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .bus_req_ni (bus_req_ni),
  .bus_addr_i (bus_addr_i),
  .bus_done_no(bus_done_no),
  .irq_l2_o   (irq_l2_o),
  .ser_tx_o   (ser_tx_o),
  .irq_en_q   (irq_en_q),
  .tx_busy    (tx_busy)
);

// File: tb/tty_bus_ctrl_tb_top.sv
`timescale 1ns/1ps
module tty_bus_ctrl_tb_top;
  localparam int CPB = 8;
  localparam logic [15:0] A_STAT = 16'hF800;
  localparam logic [15:0] A_CTRL = 16'hF806;
  localparam logic [15:0] A_DATA = 16'hF808;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_n = 1'b1;
  logic [15:0] addr = '0;
  logic        wr_n = 1'b1;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        done_n, irq, tx;
  logic        rx = 1'b1;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  tty_bus_ctrl #(.CLKS_PER_BIT(CPB)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bus_req_ni(req_n), .bus_addr_i(addr),
    .bus_wr_ni(wr_n), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .bus_done_no(done_n), .irq_l2_o(irq), .ser_tx_o(tx), .ser_rx_i(rx)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic acc(input logic [15:0] a, input bit w, input logic [7:0] d,
                     output logic [7:0] rd, output int lows);
    lows = 0; rd = 'x;
    @(negedge clk);
    addr = a; wr_n = ~w; wdata = d; req_n = 1'b0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (!done_n) begin lows++; rd = rdata; end
    end
    req_n = 1'b1; wr_n = 1'b1;
  endtask

  task automatic rd_reg(input string req, input logic [15:0] a, input logic [7:0] exp);
    logic [7:0] v; int l;
    acc(a, 1'b0, 8'h00, v, l);
    chk({req, " done"}, l, 1);
    chk(req, v, exp);
  endtask

  task automatic wr_reg(input string req, input logic [15:0] a, input logic [7:0] d);
    logic [7:0] v; int l;
    acc(a, 1'b1, d, v, l);
    chk({req, " done"}, l, 1);
  endtask

  task automatic cap_tx(output logic [10:0] fr);
    int guard = 0;
    @(negedge clk);
    while (tx && guard < 40) begin @(negedge clk); guard++; end
    repeat (CPB/2) @(negedge clk);
    fr[0] = tx;
    for (int i = 1; i < 11; i++) begin
      repeat (CPB) @(negedge clk);
      fr[i] = tx;
    end
  endtask

  task automatic send_rx(input logic [7:0] b, input bit stop1);
    logic [10:0] fr;
    fr = {1'b1, stop1, b, 1'b0};
    for (int i = 0; i < 11; i++) begin
      @(negedge clk); rx = fr[i];
      repeat (CPB-1) @(negedge clk);
    end
    @(negedge clk); rx = 1'b1;
    repeat (2*CPB) @(negedge clk);
  endtask

  initial begin
    logic [10:0] fr;
    logic [7:0]  v;
    int          l;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11 done", done_n, 1);
    chk("R11 irq", irq, 0);
    chk("R11 tx", tx, 1);
    rd_reg("R11 status", A_STAT, 8'h81);
    rd_reg("R11 control", A_CTRL, 8'h00);

    // R2 unmapped neighbours: no done, no register change
    acc(16'hF807, 1'b1, 8'h01, v, l); chk("R2 F807", l, 0);
    acc(16'hF802, 1'b1, 8'h01, v, l); chk("R2 F802", l, 0);
    acc(16'h0806, 1'b1, 8'h01, v, l); chk("R2 0806", l, 0);
    acc(16'hF818, 1'b0, 8'h00, v, l); chk("R2 F818", l, 0);
    chk("R2 irq", irq, 0);
    rd_reg("R2 control", A_CTRL, 8'h00);

    // R3 status write ignored
    wr_reg("R3 wr", A_STAT, 8'h7E);
    rd_reg("R3 status", A_STAT, 8'h81);

    // R4/R5 control and interrupt gating
    wr_reg("R4 wr", A_CTRL, 8'hFF);
    rd_reg("R4 control", A_CTRL, 8'h01);
    chk("R5 irq on", irq, 1);
    wr_reg("R4 wr0", A_CTRL, 8'h00);
    chk("R5 irq off", irq, 0);
    rd_reg("R5 pdt polled", A_STAT, 8'h81);
    wr_reg("R4 wr1", A_CTRL, 8'h01);

    // R6/R5 exhaustive transmit
    for (int b = 0; b < 256; b++) begin
      fork
        cap_tx(fr);
        begin
          wr_reg("R6 wr", A_DATA, 8'(b));
          repeat (2) @(negedge clk);
          chk("R5 irq busy", irq, 0);
        end
      join
      chk("R6 frame", fr, {2'b11, 8'(b), 1'b0});
      if (b % 64 == 0) rd_reg("R6 busy status", A_STAT, 8'h00);
      repeat (CPB) @(negedge clk);
      if (b % 64 == 0) begin
        rd_reg("R6 ready status", A_STAT, 8'h81);
        chk("R5 irq ready", irq, 1);
      end
    end

    // R7 write while busy ignored
    fork
      cap_tx(fr);
      begin
        wr_reg("R7 wr a", A_DATA, 8'h3C);
        wr_reg("R7 wr b", A_DATA, 8'hC3);
      end
    join
    chk("R7 frame", fr, {2'b11, 8'h3C, 1'b0});
    begin
      int lows_seen = 0;
      for (int i = 0; i < 4*CPB; i++) begin
        @(negedge clk);
        if (!tx) lows_seen++;
      end
      chk("R7 no second frame", lows_seen, 0);
    end

    // R8 exhaustive receive
    wr_reg("R8 irq off", A_CTRL, 8'h00);
    for (int b = 0; b < 256; b++) begin
      send_rx(8'(b), 1'b1);
      rd_reg("R8 status", A_STAT, 8'h83);
      rd_reg("R8 data", A_DATA, 8'(b));
      rd_reg("R8 cleared", A_STAT, 8'h81);
    end

    // R9 framing error
    send_rx(8'h5A, 1'b0);
    rd_reg("R9 status", A_STAT, 8'h87);
    rd_reg("R9 data", A_DATA, 8'h5A);
    rd_reg("R9 cleared", A_STAT, 8'h81);

    // R10 short glitch rejected
    @(negedge clk); rx = 1'b0;
    repeat (2) @(negedge clk); rx = 1'b1;
    repeat (12*CPB) @(negedge clk);
    rd_reg("R10 status", A_STAT, 8'h81);

    // R5 receive raises irq when enabled
    wr_reg("R5 en", A_CTRL, 8'h01);
    send_rx(8'h11, 1'b1);
    chk("R5 irq rx", irq, 1);
    rd_reg("R1 data", A_DATA, 8'h11);

    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule